// File: doc/BRIEF.md
# UART Interrupt Flag Controller

This block gathers every interrupt-causing event of a low-power serial port into one register of sticky flags and drives a single interrupt line. The events come from the transmit side, the receive side and the data buffers. Software reads the flags, forces any flag high through a write-one-to-set register, and drops any flag through a write-one-to-clear register. Each flag is gated by a bit in an enable register, and the gated bits are ORed onto `irq`.

A one-entry transmit buffer and a one-entry receive buffer, each in front of a shift-register stage, sit inside the block. This lets overflow and underflow be judged at the buffer boundary. The serializer, baud timing and frame decoding stay outside and appear only as pulses: `tx_done` ends a transmitted frame, and `rx_frame_valid` with its data and error bits delivers a received one.

The transmit path is a four-state machine. TX_IDLE means buffer and shifter are empty. TX_PENDING means the buffer is full and the shifter is empty; the data always moves to the shifter on the next edge. TX_SHIFT means the shifter is busy and the buffer is empty. TX_SHIFT_FULL means both are occupied. The transitions are: write (IDLE to PENDING, SHIFT to SHIFT_FULL), move (PENDING to SHIFT), done (SHIFT to IDLE, or SHIFT_FULL to SHIFT), and write with done (SHIFT to PENDING).

The receive path is also a four-state machine. RX_EMPTY means no frame is held. RX_SHIFT means a frame sits in the shift stage and the buffer is empty; it moves to the buffer on the next edge. RX_BUF means the buffer is full. RX_BOTH means buffer and shift stage are both full. The transitions are: frame (EMPTY to SHIFT, BUF to BOTH, SHIFT to BOTH), move (SHIFT to BUF), read (BUF to EMPTY, BOTH to SHIFT), and read with frame (BUF to SHIFT).

Register offsets on the byte-addressed bus:

| Offset | Register |
|---|---|
| 0x18 | receive data |
| 0x1C | transmit data |
| 0x2C | flags, read-only |
| 0x30 | set |
| 0x34 | clear |
| 0x38 | enable |

Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Flag bit positions are: TXC 0, TXBL 1, RXDATAV 2, RXOF 3, RXUF 4, TXOF 5, PERR 6, FERR 7, MPAF 8, STARTF 9, SIGF 10. Bits 31:11 of the flag register always read 0, even after 1s are written to them through the set register.
- R2: After reset the flag register reads 0x002 (only TXBL set), the enable register reads 0, `irq` is 0 and `tx_shift_busy` is 0.
- R3: A write to transmit data while the transmit buffer is full sets TXOF and discards the new byte. The byte already in the buffer is the one later shifted out.
- R4: A read of receive data while the receive buffer is empty returns 0 and sets RXUF.
- R5: A frame that arrives while both the buffer and the shift stage are full sets RXOF and replaces the shift-stage content. The older unread frame is lost, and the next two reads return the buffered frame and then the newest frame.
- R6: TXC sets on `tx_done` only when the transmit buffer is also empty. A `tx_done` while the buffer holds a byte does not set TXC.
- R7: TXBL sets in the cycle the buffered transmit byte moves to the shifter. `tx_shift_data` then shows that byte and `tx_shift_busy` is 1.
- R8: PERR and FERR set from a frame's error bits only while `rx_block` is 0. With `rx_block` at 1 the error bits have no effect on the flags.
- R9: Writing 1s to the set register sets those flags, and writing 1s to the clear register clears them. Zero bits in either write have no effect. A hardware set in the same cycle as a software clear of the same flag leaves the flag at 1.
- R10: `irq` is 1 exactly when some flag and its enable bit are both 1.
- R11: RXDATAV sets when a frame moves from the shift stage into the empty receive buffer, and clears when the buffer is read.
- R12: The pulses `rx_mpa_evt`, `rx_start_evt` and `rx_sig_evt` set MPAF, STARTF and SIGF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| rx_block | input | 1 | Suppresses the parity and framing error flags when 1 |
| tx_done | input | 1 | Pulse from the serializer: the current frame has been sent |
| tx_shift_data | output | DW (8) | Byte held in the transmit shift stage |
| tx_shift_busy | output | 1 | Transmit shift stage holds a byte |
| rx_frame_valid | input | 1 | Pulse: a received frame is delivered |
| rx_frame_data | input | DW (8) | Data of the received frame |
| rx_perr | input | 1 | Frame had a parity error |
| rx_ferr | input | 1 | Frame had a framing error |
| rx_mpa_evt | input | 1 | Multi-processor address frame seen |
| rx_start_evt | input | 1 | Start frame seen |
| rx_sig_evt | input | 1 | Signal frame seen |
| irq | output | 1 | Combined interrupt request |

## Verification
The flag register is first driven only by software, with all-ones, all-zeros and reserved-bit writes to the set and clear registers; this separates the register logic from the event logic. The transmit path is then walked through every state. A second write while the buffer is full tells a correct overflow, where the first byte is kept, from a last-write-wins buffer. Clearing the flags between two `tx_done` pulses shows which pulse raised TXC and which raised TXBL. On the receive side, three back-to-back frames with unique data values show which frame the overflow discarded. Frames with error bits are sent with `rx_block` both low and high. A clear that collides with a hardware event on the same flag, next to a flag with no collision, separates set priority from plain clearing.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NFLAG    = 11;

    localparam int F_TXC     = 0;
    localparam int F_TXBL    = 1;
    localparam int F_RXDATAV = 2;
    localparam int F_RXOF    = 3;
    localparam int F_RXUF    = 4;
    localparam int F_TXOF    = 5;
    localparam int F_PERR    = 6;
    localparam int F_FERR    = 7;
    localparam int F_MPAF    = 8;
    localparam int F_STARTF  = 9;
    localparam int F_SIGF    = 10;

    localparam int A_RXDATA  = 'h18;
    localparam int A_TXDATA  = 'h1C;
    localparam int A_FLAGS   = 'h2C;
    localparam int A_SET     = 'h30;
    localparam int A_CLR     = 'h34;
    localparam int A_EN      = 'h38;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PENDING,
        TX_SHIFT,
        TX_SHIFT_FULL
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_EMPTY,
        RX_SHIFT,
        RX_BUF,
        RX_BOTH
    } rx_state_e;

endpackage

// File: rtl/uirq_tx_buf.sv
module uirq_tx_buf
    import uirq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          tx_done,
    output logic [DW-1:0] shift_data,
    output logic          shift_busy,
    output logic          txof_set,
    output logic          txbl_set,
    output logic          txc_set
);

    tx_state_e     state_q, state_d;
    logic [DW-1:0] buf_q, shift_q;
    logic          load_buf, move;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            shift_q <= '0;
        end else begin
            if (load_buf) buf_q   <= wr_data;
            if (move)     shift_q <= buf_q;
        end
    end

    always_comb begin
        state_d  = state_q;
        load_buf = 1'b0;
        move     = 1'b0;
        txof_set = 1'b0;
        txbl_set = 1'b0;
        txc_set  = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (wr_en) begin
                    load_buf = 1'b1;
                    state_d  = TX_PENDING;
                end
            end
            TX_PENDING: begin
                move     = 1'b1;
                txbl_set = 1'b1;
                txof_set = wr_en;
                state_d  = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (wr_en && tx_done) begin
                    load_buf = 1'b1;
                    state_d  = TX_PENDING;
                end else if (wr_en) begin
                    load_buf = 1'b1;
                    state_d  = TX_SHIFT_FULL;
                end else if (tx_done) begin
                    txc_set  = 1'b1;
                    state_d  = TX_IDLE;
                end
            end
            TX_SHIFT_FULL: begin
                txof_set = wr_en;
                if (tx_done) begin
                    move     = 1'b1;
                    txbl_set = 1'b1;
                    state_d  = TX_SHIFT;
                end
            end
        endcase
    end

    always_comb begin
        shift_data = shift_q;
        shift_busy = (state_q == TX_SHIFT) || (state_q == TX_SHIFT_FULL);
    end

    p_txof_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT_FULL && wr_en && !tx_done) |=> (buf_q == $past(buf_q)));

    p_txc_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txc_set |=> (state_q == TX_IDLE && !shift_busy));

    p_txbl_moves_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txbl_set |=> (shift_busy && shift_data == $past(buf_q)));

endmodule

// File: rtl/uirq_rx_buf.sv
module uirq_rx_buf
    import uirq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    input  logic [DW-1:0] frame_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rxof_set,
    output logic          rxuf_set,
    output logic          rxdv_set,
    output logic          rxdv_clr
);

    rx_state_e     state_q, state_d;
    logic [DW-1:0] buf_q, shift_q;
    logic          load_shift, move;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            shift_q <= '0;
        end else begin
            if (move)       buf_q   <= shift_q;
            if (load_shift) shift_q <= frame_data;
        end
    end

    always_comb begin
        state_d    = state_q;
        load_shift = frame_valid;
        move       = 1'b0;
        rxof_set   = 1'b0;
        rxuf_set   = 1'b0;
        rxdv_set   = 1'b0;
        rxdv_clr   = 1'b0;
        unique case (state_q)
            RX_EMPTY: begin
                rxuf_set = rd_en;
                if (frame_valid) state_d = RX_SHIFT;
            end
            RX_SHIFT: begin
                move     = 1'b1;
                rxdv_set = 1'b1;
                rxuf_set = rd_en;
                state_d  = frame_valid ? RX_BOTH : RX_BUF;
            end
            RX_BUF: begin
                rxdv_clr = rd_en;
                if (rd_en && frame_valid) state_d = RX_SHIFT;
                else if (rd_en)           state_d = RX_EMPTY;
                else if (frame_valid)     state_d = RX_BOTH;
            end
            RX_BOTH: begin
                rxof_set = frame_valid;
                rxdv_clr = rd_en;
                if (rd_en) state_d = RX_SHIFT;
            end
        endcase
    end

    always_comb begin
        rd_data = ((state_q == RX_BUF) || (state_q == RX_BOTH)) ? buf_q : '0;
    end

    p_rxof_replaces_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_BOTH && frame_valid) |=> (shift_q == $past(frame_data)));

    p_rxdv_read_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_BUF && rd_en && !frame_valid) |=> (state_q == RX_EMPTY));

    p_rxuf_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rxuf_set |-> (rd_data == '0));

endmodule

// File: rtl/uirq_flag_reg.sv
module uirq_flag_reg
    import uirq_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] hw_set,
    input  logic [NF-1:0] hw_clr,
    input  logic          sw_set_we,
    input  logic          sw_clr_we,
    input  logic          en_we,
    input  logic [NF-1:0] wdata,
    output logic [NF-1:0] flags,
    output logic [NF-1:0] enables,
    output logic          irq
);

    localparam logic [NF-1:0] FLAG_RST = NF'(1) << F_TXBL;

    logic [NF-1:0] flags_q, flags_d, en_q, sw_set, sw_clr;

    always_comb begin
        sw_set  = sw_set_we ? wdata : '0;
        sw_clr  = sw_clr_we ? wdata : '0;
        flags_d = (flags_q & ~sw_clr & ~hw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= FLAG_RST;
            en_q    <= '0;
        end else begin
            flags_q <= flags_d;
            if (en_we) en_q <= wdata;
        end
    end

    always_comb begin
        flags   = flags_q;
        enables = en_q;
        irq     = |(flags_q & en_q);
    end

    for (genvar i = 0; i < NF; i++) begin : g_chk
        p_hw_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> flags_q[i]);
        p_w1s_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_set_we && wdata[i]) |=> flags_q[i]);
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_block,
    input  logic              tx_done,
    output logic [DW-1:0]     tx_shift_data,
    output logic              tx_shift_busy,
    input  logic              rx_frame_valid,
    input  logic [DW-1:0]     rx_frame_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_mpa_evt,
    input  logic              rx_start_evt,
    input  logic              rx_sig_evt,
    output logic              irq
);

    localparam int NF = NFLAG;

    logic          tx_wr, rx_rd, set_we, clr_we, en_we;
    logic          txof_set, txbl_set, txc_set;
    logic          rxof_set, rxuf_set, rxdv_set, rxdv_clr;
    logic [DW-1:0] rx_rd_data;
    logic [NF-1:0] hw_set, hw_clr, flags, enables;
    logic          unused_wdata;

    assign unused_wdata = ^bus_wdata[31:NF];

    always_comb begin
        tx_wr  = bus_wr && (bus_addr == ADDR_W'(A_TXDATA));
        set_we = bus_wr && (bus_addr == ADDR_W'(A_SET));
        clr_we = bus_wr && (bus_addr == ADDR_W'(A_CLR));
        en_we  = bus_wr && (bus_addr == ADDR_W'(A_EN));
        rx_rd  = bus_rd && (bus_addr == ADDR_W'(A_RXDATA));
    end

    uirq_tx_buf #(.DW(DW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tx_wr),
        .wr_data    (bus_wdata[DW-1:0]),
        .tx_done    (tx_done),
        .shift_data (tx_shift_data),
        .shift_busy (tx_shift_busy),
        .txof_set   (txof_set),
        .txbl_set   (txbl_set),
        .txc_set    (txc_set)
    );

    uirq_rx_buf #(.DW(DW)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (rx_frame_valid),
        .frame_data  (rx_frame_data),
        .rd_en       (rx_rd),
        .rd_data     (rx_rd_data),
        .rxof_set    (rxof_set),
        .rxuf_set    (rxuf_set),
        .rxdv_set    (rxdv_set),
        .rxdv_clr    (rxdv_clr)
    );

    always_comb begin
        hw_set            = '0;
        hw_clr            = '0;
        hw_set[F_TXC]     = txc_set;
        hw_set[F_TXBL]    = txbl_set;
        hw_set[F_RXDATAV] = rxdv_set;
        hw_set[F_RXOF]    = rxof_set;
        hw_set[F_RXUF]    = rxuf_set;
        hw_set[F_TXOF]    = txof_set;
        hw_set[F_PERR]    = rx_frame_valid && rx_perr && !rx_block;
        hw_set[F_FERR]    = rx_frame_valid && rx_ferr && !rx_block;
        hw_set[F_MPAF]    = rx_mpa_evt;
        hw_set[F_STARTF]  = rx_start_evt;
        hw_set[F_SIGF]    = rx_sig_evt;
        hw_clr[F_RXDATAV] = rxdv_clr;
    end

    uirq_flag_reg #(.NF(NF)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_set    (hw_set),
        .hw_clr    (hw_clr),
        .sw_set_we (set_we),
        .sw_clr_we (clr_we),
        .en_we     (en_we),
        .wdata     (bus_wdata[NF-1:0]),
        .flags     (flags),
        .enables   (enables),
        .irq       (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr == ADDR_W'(A_RXDATA))     bus_rdata <= 32'(rx_rd_data);
            else if (bus_addr == ADDR_W'(A_FLAGS)) bus_rdata <= 32'(flags);
            else if (bus_addr == ADDR_W'(A_EN))    bus_rdata <= 32'(enables);
            else                                   bus_rdata <= '0;
        end
    end

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(A_FLAGS)) |=> (bus_rdata[31:NF] == '0));

    p_perr_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_block && !(set_we && bus_wdata[F_PERR]) && !flags[F_PERR]) |=> !flags[F_PERR]);

endmodule

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_block = 1'b0, tx_done = 1'b0;
    logic [7:0]  tx_shift_data;
    logic        tx_shift_busy;
    logic        rx_frame_valid = 1'b0;
    logic [7:0]  rx_frame_data = '0;
    logic        rx_perr = 1'b0, rx_ferr = 1'b0;
    logic        rx_mpa_evt = 1'b0, rx_start_evt = 1'b0, rx_sig_evt = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_d = 1'b0;

    localparam logic [7:0] RXD = 8'h18, TXD = 8'h1C, FLG = 8'h2C,
                           SET = 8'h30, CLR = 8'h34, ENR = 8'h38;

    always #2.5 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_block(rx_block), .tx_done(tx_done), .tx_shift_data(tx_shift_data),
        .tx_shift_busy(tx_shift_busy), .rx_frame_valid(rx_frame_valid),
        .rx_frame_data(rx_frame_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_mpa_evt(rx_mpa_evt), .rx_start_evt(rx_start_evt),
        .rx_sig_evt(rx_sig_evt), .irq(irq)
    );

    always @(posedge clk) rd_d <= bus_rd;

    // monitor: pops the expected read data and compares
    always @(negedge clk) begin
        if (rd_d) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: read got 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", t, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
        tick();
    endtask

    task automatic br(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        tick();
    endtask

    task automatic frame(input logic [7:0] d, input logic pe, input logic fe);
        rx_frame_valid = 1'b1; rx_frame_data = d; rx_perr = pe; rx_ferr = fe;
        tick();
        rx_frame_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
        tick();
        tick();
    endtask

    task automatic done_pulse();
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2 reset state
        br(FLG, 32'h002, "R2 flags after reset");
        br(ENR, 32'h000, "R2 enable after reset");
        chk(irq, 0, "R2 irq after reset");
        chk(tx_shift_busy, 0, "R2 shifter idle after reset");

        // R9 / R1 software set and clear
        bw(SET, 32'h7FF);
        br(FLG, 32'h7FF, "R9 set all");
        bw(SET, 32'hFFFF_F800);
        br(FLG, 32'h7FF, "R1 reserved bits read zero");
        bw(CLR, 32'hFFFF_FFFF);
        br(FLG, 32'h000, "R9 clear all");
        bw(SET, 32'h000);
        br(FLG, 32'h000, "R9 zero write no effect");
        bw(SET, 32'h002);
        bw(CLR, 32'h000);
        br(FLG, 32'h002, "R9 single set, zero clear");

        // R10 interrupt gating
        bw(ENR, 32'h004);
        chk(irq, 0, "R10 enabled flag not set");
        bw(SET, 32'h004);
        chk(irq, 1, "R10 enabled flag set");
        bw(CLR, 32'h004);
        chk(irq, 0, "R10 flag cleared");
        bw(ENR, 32'h000);
        bw(CLR, 32'h7FF);

        // transmit path: R7, R3, R6
        bw(TXD, 32'hA5);
        chk(tx_shift_data, 8'hA5, "R7 byte moved to shifter");
        chk(tx_shift_busy, 1, "R7 shifter busy");
        br(FLG, 32'h002, "R7 TXBL on move");
        bw(TXD, 32'h3C);
        bw(TXD, 32'h77);
        br(FLG, 32'h022, "R3 TXOF on full write");
        bw(CLR, 32'h002);
        done_pulse();
        chk(tx_shift_data, 8'h3C, "R3 older byte kept");
        br(FLG, 32'h022, "R6 no TXC with buffer full, R7 TXBL again");
        bw(CLR, 32'h7FF);
        done_pulse();
        chk(tx_shift_busy, 0, "R6 shifter empty");
        br(FLG, 32'h001, "R6 TXC when both empty");

        // receive path: R4, R11, R5
        bw(CLR, 32'h7FF);
        br(RXD, 32'h00, "R4 empty read returns 0");
        br(FLG, 32'h010, "R4 RXUF");
        frame(8'h11, 0, 0);
        br(FLG, 32'h014, "R11 RXDATAV on arrival");
        frame(8'h22, 0, 0);
        frame(8'h33, 0, 0);
        br(FLG, 32'h01C, "R5 RXOF");
        br(RXD, 32'h11, "R5 buffered frame first");
        br(RXD, 32'h33, "R5 newest frame replaced lost one");
        br(FLG, 32'h018, "R11 RXDATAV cleared on read");

        // R8 error suppression
        bw(CLR, 32'h7FF);
        frame(8'h44, 1, 0);
        br(FLG, 32'h044, "R8 PERR with block low");
        br(RXD, 32'h44, "R8 frame data");
        bw(CLR, 32'h7FF);
        rx_block = 1'b1;
        frame(8'h55, 1, 1);
        br(FLG, 32'h004, "R8 errors ignored while blocked");
        br(RXD, 32'h55, "R8 blocked frame data");
        rx_block = 1'b0;
        bw(CLR, 32'h7FF);
        frame(8'h66, 0, 1);
        br(FLG, 32'h084, "R8 FERR with block low");
        br(RXD, 32'h66, "R8 frame data 2");

        // R12 event flags
        rx_mpa_evt = 1'b1; rx_start_evt = 1'b1; rx_sig_evt = 1'b1;
        tick();
        rx_mpa_evt = 1'b0; rx_start_evt = 1'b0; rx_sig_evt = 1'b0;
        tick();
        br(FLG, 32'h780, "R12 MPAF STARTF SIGF");

        // R9 hardware set beats software clear
        bus_wr = 1'b1; bus_addr = CLR; bus_wdata = 32'h500; rx_sig_evt = 1'b1;
        tick();
        bus_wr = 1'b0; rx_sig_evt = 1'b0;
        tick();
        br(FLG, 32'h680, "R9 hw set wins over clear");

        // R10 with hardware flag
        bw(ENR, 32'h001);
        chk(irq, 0, "R10 enable of clear flag");
        bw(ENR, 32'h080);
        chk(irq, 1, "R10 FERR enabled");
        br(ENR, 32'h080, "R10 enable readback");
        bw(CLR, 32'h080);
        chk(irq, 0, "R10 after clearing FERR");
        br(FLG, 32'h600, "R9 remaining flags");

        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule